// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block moves a CPU from ordinary execution into an interrupt handler. While the CPU runs, the block watches a pending request. It acts only when the CPU signals an instruction boundary. Once it takes a request, the block stores the program counter (and, in vectored mode, the status word) on a dedicated interrupt stack through a word-wide memory port. It then hands the CPU a new program counter and status word in a single-cycle `done` pulse. The CPU loads both values and resumes in the handler. General registers stay the handler's job.

Two entry styles are chosen per request by `vec_mode`, which is sampled at acceptance.

**Vectored mode.** The device supplies a vector word during a one-cycle acknowledge. The new status word is read from the vector address plus one, and the new PC from the vector address itself. The new status word carries the handler's priority level.

**Fixed mode.** There are only two priority states: enabled and disabled. The block clears the enable bit, pushes the PC, and branches to a constant address. No vector is fetched and no status word is pushed.

The memory port is a valid/ready pair. `mem_req` acts as valid and `mem_ack` as ready. Once `mem_req` rises, the address, write flag and write data are held unchanged until the cycle in which `mem_ack` is seen high. The transfer completes in that cycle, and the memory may stall for any number of cycles before it. Read data is taken in the `mem_ack` cycle.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `irq_ack` and `mem_req` are low and `isp` equals ISP_INIT (default 16'hFF00).
- R2: A request is taken only on a clock edge where `insn_boundary` and `irq_req` are both high and the block is idle. In vectored mode it must also satisfy `irq_prio` > `cpu_psw[2:0]`. A request at or below that level, or without a boundary strobe, leaves `busy` low and the memory port quiet.
- R3: In vectored mode the block performs these steps in order: one `irq_ack` cycle latching `irq_vec`, a write of the PC, a write of the status word, a read at vector+1, and a read at vector.
- R4: The interrupt stack grows downward. `isp` drops by one before every push, so the first push goes to `isp`−1 and the second to `isp`−2; `isp` never changes by any other amount.
- R5: Each memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`, and the sequence waits in each access for as long as `mem_ack` stays low.
- R6: `done` is high for exactly one cycle. It presents `new_pc` and `new_psw`. `busy` is high from the cycle after acceptance through the `done` cycle, and low right after it.
- R7: In vectored mode `new_pc` is the word read at the vector and `new_psw` is the word read at vector+1.
- R8: In fixed mode a request is taken whenever `cpu_psw[3]` (interrupt enable) is 1, whatever its priority. There is no `irq_ack`, and only the PC is pushed. `new_pc` equals FIXED_ADDR (default 16'h0010), and `new_psw` is the old status word with bit 3 cleared.
- R9: The values pushed are those of `cpu_pc` and `cpu_psw` on the acceptance edge; later changes to those inputs do not affect them.
- R10: Once the CPU loads `new_psw`, a vectored request at a priority equal to that new level is held off, and one a level higher is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | CPU is between instructions this cycle |
| vec_mode | input | 1 | 1 = vectored entry, 0 = fixed-address entry |
| irq_req | input | 1 | Interrupt request pending |
| irq_prio | input | 3 | Priority of the pending request |
| irq_vec | input | 16 | Device vector, valid while `irq_ack` is high |
| irq_ack | output | 1 | One-cycle acknowledge; vector latched here |
| cpu_pc | input | 16 | Current program counter |
| cpu_psw | input | 16 | Current status word: [2:0] level, [3] enable |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory ready; access completes |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse: load `new_pc`/`new_psw` |
| new_pc | output | 16 | Handler program counter |
| new_psw | output | 16 | Handler status word |
| isp | output | 16 | Interrupt stack pointer |

## Verification
The assertions assume that the memory side never raises `mem_ack` without a pending `mem_req`. They also assume that `irq_vec` is valid during the acknowledge cycle and that the CPU holds off a new boundary strobe until it has loaded the status word from `done`.

The stimulus keeps to these rules in two ways. A responder model acknowledges only open requests, after a per-test delay of 0 to 5 cycles. The bench holds the vector steady for the whole request and updates the status word from `done` before it tries the next request.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_RD_PSW,
    ST_RD_PC,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/intr_accept.sv
module intr_accept #(
  parameter int PW = 3
) (
  input  logic          idle,
  input  logic          insn_boundary,
  input  logic          irq_req,
  input  logic [PW-1:0] irq_prio,
  input  logic          vec_mode,
  input  logic [PW:0]   psw_ctl,
  output logic          take
);
  logic above_level;
  logic enabled;

  assign above_level = irq_prio > psw_ctl[PW-1:0];
  assign enabled     = psw_ctl[PW];
  assign take = idle && insn_boundary && irq_req && (vec_mode ? above_level : enabled);
endmodule

// File: rtl/intr_isp.sv
module intr_isp #(
  parameter int          W        = 16,
  parameter logic [W-1:0] ISP_INIT = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec,
  output logic [W-1:0] isp
);
  always_ff @(posedge clk) begin
    if (!rst_n) isp <= ISP_INIT;
    else if (dec) isp <= isp - W'(1);
  end

  AST_ISP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(isp) |-> isp == $past(isp) - W'(1)); // R4
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
  import intr_seq_pkg::*;
#(
  parameter int          W          = 16,
  parameter int          PW         = 3,
  parameter logic [W-1:0] FIXED_ADDR = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         vec_mode,
  input  logic [W-1:0] irq_vec,
  input  logic [W-1:0] cpu_pc,
  input  logic [W-1:0] cpu_psw,
  input  logic [W-1:0] isp,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         irq_ack,
  output logic         isp_dec,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] new_pc,
  output logic [W-1:0] new_psw
);
  localparam int IE_BIT = PW;
  localparam logic [W-1:0] IE_MASK = W'(1) << IE_BIT;

  seq_state_e state, nxt;
  logic         mode_r;
  logic [W-1:0] vec_r, pc_r, psw_r, npc_r, npsw_r;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (take) nxt = vec_mode ? ST_ACK : ST_PUSH_PC;
      ST_ACK:      nxt = ST_PUSH_PC;
      ST_PUSH_PC:  if (mem_ack) nxt = mode_r ? ST_PUSH_PSW : ST_DONE;
      ST_PUSH_PSW: if (mem_ack) nxt = ST_RD_PSW;
      ST_RD_PSW:   if (mem_ack) nxt = ST_RD_PC;
      ST_RD_PC:    if (mem_ack) nxt = ST_DONE;
      ST_DONE:     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_r <= 1'b0;
      vec_r  <= '0;
      pc_r   <= '0;
      psw_r  <= '0;
      npc_r  <= '0;
      npsw_r <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && take) begin
        mode_r <= vec_mode;
        pc_r   <= cpu_pc;
        psw_r  <= cpu_psw;
        if (!vec_mode) begin
          npc_r  <= FIXED_ADDR;
          npsw_r <= cpu_psw & ~IE_MASK;
        end
      end
      if (state == ST_ACK) vec_r <= irq_vec;
      if (state == ST_RD_PSW && mem_ack) npsw_r <= mem_rdata;
      if (state == ST_RD_PC && mem_ack) npc_r <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_PUSH_PC:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = isp; mem_wdata = pc_r; end
      ST_PUSH_PSW: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = isp; mem_wdata = psw_r; end
      ST_RD_PSW:   begin mem_req = 1'b1; mem_addr = vec_r + W'(1); end
      ST_RD_PC:    begin mem_req = 1'b1; mem_addr = vec_r; end
      default:     ;
    endcase
  end

  assign isp_dec = (state == ST_IDLE && take && !vec_mode) || (state == ST_ACK)
                || (state == ST_PUSH_PC && mem_ack && mode_r);
  assign irq_ack = (state == ST_ACK);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign new_pc  = npc_r;
  assign new_psw = npsw_r;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack); // R3
  AST_PC_PUSH_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (mem_req && mem_we && mem_addr == isp)); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && mem_ack)); // R6
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R6
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int            W          = 16,
  parameter int            PW         = 3,
  parameter logic [W-1:0]  FIXED_ADDR = 16'h0010,
  parameter logic [W-1:0]  ISP_INIT   = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_boundary,
  input  logic          vec_mode,
  input  logic          irq_req,
  input  logic [PW-1:0] irq_prio,
  input  logic [W-1:0]  irq_vec,
  output logic          irq_ack,
  input  logic [W-1:0]  cpu_pc,
  input  logic [W-1:0]  cpu_psw,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  new_pc,
  output logic [W-1:0]  new_psw,
  output logic [W-1:0]  isp
);
  logic take;
  logic isp_dec;

  intr_accept #(.PW(PW)) u_accept (
    .idle          (!busy),
    .insn_boundary (insn_boundary),
    .irq_req       (irq_req),
    .irq_prio      (irq_prio),
    .vec_mode      (vec_mode),
    .psw_ctl       (cpu_psw[PW:0]),
    .take          (take)
  );

  intr_isp #(.W(W), .ISP_INIT(ISP_INIT)) u_isp (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (isp_dec),
    .isp   (isp)
  );

  intr_fsm #(.W(W), .PW(PW), .FIXED_ADDR(FIXED_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .vec_mode  (vec_mode),
    .irq_vec   (irq_vec),
    .cpu_pc    (cpu_pc),
    .cpu_psw   (cpu_psw),
    .isp       (isp),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .irq_ack   (irq_ack),
    .isp_dec   (isp_dec),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .new_pc    (new_pc),
    .new_psw   (new_psw)
  );

  AST_ENTRY_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_boundary && irq_req)); // R2
endmodule

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FIXED = 16'h0010;
  localparam logic [15:0] ISP0  = 16'hFF00;

  typedef struct packed {
    logic        mode;
    logic        acc;
    logic [2:0]  prio;
    logic [15:0] psw;
    logic [15:0] pc;
    logic [15:0] vec;
    logic [3:0]  lat;
  } ent_t;

  localparam ent_t TBL [8] = '{
    '{1'b1, 1'b1, 3'd5, 16'h0002, 16'h1000, 16'h0040, 4'd0},
    '{1'b1, 1'b0, 3'd2, 16'h0002, 16'h1100, 16'h0044, 4'd0},
    '{1'b1, 1'b1, 3'd7, 16'h0006, 16'h2222, 16'h0100, 4'd3},
    '{1'b1, 1'b0, 3'd1, 16'h0003, 16'h2300, 16'h0104, 4'd1},
    '{1'b0, 1'b1, 3'd0, 16'h0008, 16'h3333, 16'h0000, 4'd2},
    '{1'b0, 1'b0, 3'd7, 16'h0000, 16'h3400, 16'h0000, 4'd0},
    '{1'b1, 1'b1, 3'd4, 16'h000B, 16'h4444, 16'h0200, 4'd1},
    '{1'b0, 1'b1, 3'd0, 16'h000F, 16'h5555, 16'h0000, 4'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_boundary = 1'b0, vec_mode = 1'b1, irq_req = 1'b0;
  logic [2:0] irq_prio = '0;
  logic [15:0] irq_vec = '0, cpu_pc = '0, cpu_psw = '0;
  logic irq_ack, mem_req, mem_we, busy, done;
  logic [15:0] mem_addr, mem_wdata, new_pc, new_psw, isp;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int total = 0, bad = 0, cycles = 0;
  int lat = 0, cnt = 0, ln = 0, stab_err = 0;
  logic [15:0] a0 = '0;
  logic [15:0] la [128];
  logic        lw [128];
  logic [15:0] ld [128];
  logic [15:0] exp_isp = ISP0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_seq i_intr_entry_seq (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .vec_mode(vec_mode),
    .irq_req(irq_req), .irq_prio(irq_prio), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .cpu_pc(cpu_pc), .cpu_psw(cpu_psw), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .new_pc(new_pc), .new_psw(new_psw), .isp(isp)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a ^ 16'hC3A5;
  endfunction

  // memory responder: acknowledges only open requests after lat idle cycles
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && mem_ack) begin
      la[ln % 128] <= mem_addr;
      lw[ln % 128] <= mem_we;
      ld[ln % 128] <= mem_wdata;
      ln <= ln + 1;
      if (mem_addr !== a0) stab_err <= stab_err + 1;
    end
    if (mem_req && !mem_ack) begin
      if (cnt == 0) a0 <= mem_addr;
      if (cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memf(mem_addr);
      end else cnt <= cnt + 1;
    end else begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input ent_t e, input string tag, output logic [15:0] got_psw);
    int base;
    int acks;
    bit seen;
    logic [15:0] got_pc;
    got_psw = '0;
    got_pc = '0;
    acks = 0;
    seen = 0;
    base = ln;
    lat = int'(e.lat);
    vec_mode = e.mode;
    cpu_pc = e.pc;
    cpu_psw = e.psw;
    irq_prio = e.prio;
    irq_vec = e.vec;
    irq_req = 1'b1;
    insn_boundary = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0;
    cpu_pc = ~e.pc;          // R9: later changes must not reach the stack
    cpu_psw = e.psw ^ 16'h0F00;
    chk("R2", {tag, " busy after boundary"}, 32'(busy), 32'(e.acc));
    if (e.acc) begin
      for (int k = 0; k < 200; k++) begin
        if (irq_ack) acks++;
        if (done) begin
          seen = 1;
          got_pc = new_pc;
          got_psw = new_psw;
          chk("R6", {tag, " busy with done"}, 32'(busy), 32'd1);
          break;
        end
        @(negedge clk);
      end
      chk("R6", {tag, " done seen"}, 32'(seen), 32'd1);
      @(negedge clk);
      chk("R6", {tag, " done single cycle"}, 32'(done), 32'd0);
      chk("R6", {tag, " busy low after done"}, 32'(busy), 32'd0);
      irq_req = 1'b0;
      if (e.mode) begin
        chk("R3", {tag, " ack count"}, 32'(acks), 32'd1);
        chk("R3", {tag, " access count"}, 32'(ln - base), 32'd4);
        chk("R4", {tag, " pc push addr"}, {15'd0, lw[base % 128], la[base % 128]}, {15'd0, 1'b1, exp_isp - 16'd1});
        chk("R9", {tag, " pc pushed"}, 32'(ld[base % 128]), 32'(e.pc));
        chk("R4", {tag, " psw push addr"}, {15'd0, lw[(base+1) % 128], la[(base+1) % 128]}, {15'd0, 1'b1, exp_isp - 16'd2});
        chk("R9", {tag, " psw pushed"}, 32'(ld[(base+1) % 128]), 32'(e.psw));
        chk("R3", {tag, " read vec+1"}, {15'd0, lw[(base+2) % 128], la[(base+2) % 128]}, {15'd0, 1'b0, e.vec + 16'd1});
        chk("R3", {tag, " read vec"}, {15'd0, lw[(base+3) % 128], la[(base+3) % 128]}, {15'd0, 1'b0, e.vec});
        chk("R7", {tag, " new pc"}, 32'(got_pc), 32'(memf(e.vec)));
        chk("R7", {tag, " new psw"}, 32'(got_psw), 32'(memf(e.vec + 16'd1)));
        exp_isp = exp_isp - 16'd2;
      end else begin
        chk("R8", {tag, " no ack"}, 32'(acks), 32'd0);
        chk("R8", {tag, " access count"}, 32'(ln - base), 32'd1);
        chk("R4", {tag, " pc push addr"}, {15'd0, lw[base % 128], la[base % 128]}, {15'd0, 1'b1, exp_isp - 16'd1});
        chk("R9", {tag, " pc pushed"}, 32'(ld[base % 128]), 32'(e.pc));
        chk("R8", {tag, " new pc"}, 32'(got_pc), 32'(FIXED));
        chk("R8", {tag, " new psw"}, 32'(got_psw), 32'(e.psw & ~16'h0008));
        exp_isp = exp_isp - 16'd1;
      end
      chk("R4", {tag, " isp"}, 32'(isp), 32'(exp_isp));
    end else begin
      bit quiet = 1;
      repeat (6) begin
        @(negedge clk);
        if (busy || mem_req || irq_ack) quiet = 0;
      end
      irq_req = 1'b0;
      chk("R2", {tag, " ignored stays quiet"}, 32'(quiet), 32'd1);
      chk("R2", {tag, " no access"}, 32'(ln - base), 32'd0);
      chk("R4", {tag, " isp unchanged"}, 32'(isp), 32'(exp_isp));
    end
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] npsw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "ack", 32'(irq_ack), 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    chk("R1", "isp", 32'(isp), 32'(ISP0));

    // R2: request without boundary strobe is ignored
    begin
      bit quiet = 1;
      vec_mode = 1'b1;
      irq_req = 1'b1;
      irq_prio = 3'd7;
      cpu_psw = 16'h0000;
      repeat (8) begin
        @(negedge clk);
        if (busy || mem_req) quiet = 0;
      end
      irq_req = 1'b0;
      chk("R2", "no boundary no entry", 32'(quiet), 32'd1);
    end

    for (int i = 0; i < 8; i++) begin
      run(TBL[i], $sformatf("tbl%0d", i), npsw);
      repeat (2) @(negedge clk);
    end

    // R10: new level from the handler's status word holds off equal requests
    run('{1'b1, 1'b1, 3'd7, 16'h0000, 16'h6000, 16'h0300, 4'd2}, "r10_entry", npsw);
    chk("R10", "loaded level", 32'(npsw[2:0]), 32'd4);
    run('{1'b1, 1'b0, 3'd4, memf(16'h0301), 16'h6100, 16'h0400, 4'd0}, "r10_equal", npsw);
    run('{1'b1, 1'b1, 3'd5, memf(16'h0301), 16'h6200, 16'h0400, 4'd4}, "r10_higher", npsw);

    chk("R5", "address stable through waits", 32'(stab_err), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule